// File: doc/BRIEF.md
# Register Producer Tag Table

This block records, for every architectural register of one register class, whether the register file holds its current value or whether that value is still owed by an instruction in flight. For an owed register it keeps the reorder-buffer tag of the instruction that will write it. The issue stage marks the destination register of each new instruction as owed and records the tail tag. The retire stage marks a register current again when the head entry writes it back, but only if the tag it carries is still the one the table holds for that register. Operand lookups read the table combinationally.

Each entry is a two-state machine. In state `ENT_READY` the register file value is current. In state `ENT_PENDING` the value is owed by the recorded tag. The transitions are: *flush* (any state to `ENT_READY`, tag zero, on clear or reset); *claim* (any state to `ENT_PENDING`, tag loaded, on an issue write to the entry); *release* (`ENT_PENDING` to `ENT_READY`, tag kept, on a writeback to the entry whose tag matches); *hold* (no change in any other case). Priority is flush, then claim, then release. One instance serves one register class. With `HALF_MODE` set, the entry index is register bits 4 down to 1, so the table has 16 entries for floating-point halves. With `ZERO_REG` set, register 0 always reads as current.

Top module: `prod_tag_table`

## Requirements
- R1: After reset, every entry reads valid (1) with tag 0.
- R2: An issue write sets the addressed entry to pending: it reads valid 0 and holds the issue tag.
- R3: A writeback whose tag equals the stored tag of the addressed entry makes that entry valid and leaves its tag unchanged.
- R4: A writeback whose tag differs from the stored tag of the addressed entry leaves that entry unchanged.
- R5: When issue and writeback address the same entry in the same cycle, the issue write is applied and the writeback is ignored.
- R6: A cycle with clear high sets every entry to valid with tag 0, whatever the issue and writeback ports carry in that cycle.
- R7: Entries addressed by neither port keep their state. An issue and a writeback to different entries in the same cycle both take effect.
- R8: Read ports are combinational and show the state registered before the current cycle's updates. An update becomes visible in the cycle after its clock edge.
- R9: With ZERO_REG=1, a lookup of register 0 returns valid 1 and tag 0, even after an issue to register 0.
- R10: With HALF_MODE=1, the entry index is register bits [4:1], which gives 16 entries, so registers 2k and 2k+1 share one entry.
- R11: Each of the RD_PORTS read ports looks up its own address independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Flush all entries to valid, tag 0 |
| iss_en | input | 1 | Issue write enable |
| iss_reg | input | ADDR_W | Issue destination register |
| iss_tag | input | TAG_W | Tag from the buffer tail |
| wb_en | input | 1 | Writeback enable |
| wb_reg | input | ADDR_W | Writeback destination register |
| wb_tag | input | TAG_W | Tag from the buffer head |
| rd_reg | input | RD_PORTS*ADDR_W | Lookup registers, port p at bits [p*ADDR_W +: ADDR_W] |
| rd_valid | output | RD_PORTS | Per-port valid |
| rd_tag | output | RD_PORTS*TAG_W | Per-port producer tag, port p at bits [p*TAG_W +: TAG_W] |

## Verification
The bench goes after stale retirement. In that case a younger issue re-claims a register, and then the older instruction retires. A design that skipped the tag compare would mark the register current too early, and consumers would read stale data. The bench also drives issue and writeback to one entry in the same cycle, where a design with the wrong priority would lose the new claim. It issues to register 0 and checks that lookups still see it as current. It pairs sibling registers on the half-indexed instance, where a design with the wrong index slice would split or alias the wrong entries. Finally, it asserts clear together with both write ports, where a design with clear at the wrong priority would leave an entry pending.

// File: rtl/prodtab_pkg.sv
package prodtab_pkg;
    typedef enum logic {
        ENT_READY   = 1'b0,
        ENT_PENDING = 1'b1
    } ent_state_e;
endpackage

// File: rtl/prodtab_index.sv
module prodtab_index #(
    parameter int ADDR_W    = 5,
    parameter bit HALF_MODE = 1'b0,
    localparam int IDX_W    = HALF_MODE ? ADDR_W - 1 : ADDR_W
) (
    input  logic [ADDR_W-1:0] reg_num,
    output logic [IDX_W-1:0]  idx
);
    generate
        if (HALF_MODE) begin : g_half
            assign idx = reg_num[ADDR_W-1:1];
        end else begin : g_full
            assign idx = reg_num;
        end
    endgenerate
endmodule

// File: rtl/prodtab_entry.sv
module prodtab_entry
    import prodtab_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             iss_hit,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             wb_hit,
    input  logic [TAG_W-1:0] wb_tag,
    output logic             ent_valid,
    output logic [TAG_W-1:0] ent_tag
);
    ent_state_e       state, nxt_state;
    logic [TAG_W-1:0] tag_q, nxt_tag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ENT_READY;
            tag_q <= '0;
        end else begin
            state <= nxt_state;
            tag_q <= nxt_tag;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_tag   = tag_q;
        if (clear) begin
            nxt_state = ENT_READY;
            nxt_tag   = '0;
        end else if (iss_hit) begin
            nxt_state = ENT_PENDING;
            nxt_tag   = iss_tag;
        end else if (wb_hit && (wb_tag == tag_q)) begin
            unique case (state)
                ENT_PENDING: nxt_state = ENT_READY;
                ENT_READY:   nxt_state = ENT_READY;
            endcase
        end
    end

    always_comb begin
        ent_valid = (state == ENT_READY);
        ent_tag   = tag_q;
    end

    assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state == ENT_READY) && (tag_q == '0));

    assert_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && iss_hit) |=> (state == ENT_PENDING) && (tag_q == $past(iss_tag)));

    assert_same_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && iss_hit && wb_hit) |=> (state == ENT_PENDING));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !iss_hit && wb_hit && (wb_tag == tag_q)) |=> (state == ENT_READY) && $stable(tag_q));

    assert_stale_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !iss_hit && wb_hit && (wb_tag != tag_q)) |=> $stable(state) && $stable(tag_q));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !iss_hit && !wb_hit) |=> $stable(state) && $stable(tag_q));
endmodule

// File: rtl/prodtab_readmux.sv
module prodtab_readmux #(
    parameter int ADDR_W    = 5,
    parameter int TAG_W     = 4,
    parameter int RD_PORTS  = 2,
    parameter bit HALF_MODE = 1'b0,
    parameter bit ZERO_REG  = 1'b1,
    localparam int IDX_W    = HALF_MODE ? ADDR_W - 1 : ADDR_W,
    localparam int DEPTH    = 1 << IDX_W
) (
    input  logic [DEPTH-1:0]          ent_valid,
    input  logic [DEPTH*TAG_W-1:0]    ent_tag,
    input  logic [RD_PORTS*ADDR_W-1:0] rd_reg,
    output logic [RD_PORTS-1:0]       rd_valid,
    output logic [RD_PORTS*TAG_W-1:0] rd_tag
);
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] reg_num;
        logic              pinned;

        assign reg_num = rd_reg[p*ADDR_W +: ADDR_W];

        prodtab_index #(.ADDR_W(ADDR_W), .HALF_MODE(HALF_MODE)) u_idx (
            .reg_num (reg_num),
            .idx     (idx)
        );

        assign pinned = ZERO_REG && (reg_num == '0);

        always_comb begin
            if (pinned) begin
                rd_valid[p]              = 1'b1;
                rd_tag[p*TAG_W +: TAG_W] = '0;
            end else begin
                rd_valid[p]              = ent_valid[idx];
                rd_tag[p*TAG_W +: TAG_W] = ent_tag[idx*TAG_W +: TAG_W];
            end
        end
    end
endmodule

// File: rtl/prod_tag_table.sv
module prod_tag_table #(
    parameter int ADDR_W    = 5,
    parameter int TAG_W     = 4,
    parameter int RD_PORTS  = 2,
    parameter bit HALF_MODE = 1'b0,
    parameter bit ZERO_REG  = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       iss_en,
    input  logic [ADDR_W-1:0]          iss_reg,
    input  logic [TAG_W-1:0]           iss_tag,
    input  logic                       wb_en,
    input  logic [ADDR_W-1:0]          wb_reg,
    input  logic [TAG_W-1:0]           wb_tag,
    input  logic [RD_PORTS*ADDR_W-1:0] rd_reg,
    output logic [RD_PORTS-1:0]        rd_valid,
    output logic [RD_PORTS*TAG_W-1:0]  rd_tag
);
    localparam int IDX_W = HALF_MODE ? ADDR_W - 1 : ADDR_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0]       iss_idx, wb_idx;
    logic [DEPTH-1:0]       ent_valid;
    logic [DEPTH*TAG_W-1:0] ent_tag;

    prodtab_index #(.ADDR_W(ADDR_W), .HALF_MODE(HALF_MODE)) u_iss_idx (
        .reg_num (iss_reg),
        .idx     (iss_idx)
    );

    prodtab_index #(.ADDR_W(ADDR_W), .HALF_MODE(HALF_MODE)) u_wb_idx (
        .reg_num (wb_reg),
        .idx     (wb_idx)
    );

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic iss_hit, wb_hit;
        assign iss_hit = iss_en && (iss_idx == IDX_W'(e));
        assign wb_hit  = wb_en  && (wb_idx  == IDX_W'(e));

        prodtab_entry #(.TAG_W(TAG_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (clear),
            .iss_hit   (iss_hit),
            .iss_tag   (iss_tag),
            .wb_hit    (wb_hit),
            .wb_tag    (wb_tag),
            .ent_valid (ent_valid[e]),
            .ent_tag   (ent_tag[e*TAG_W +: TAG_W])
        );
    end

    prodtab_readmux #(
        .ADDR_W    (ADDR_W),
        .TAG_W     (TAG_W),
        .RD_PORTS  (RD_PORTS),
        .HALF_MODE (HALF_MODE),
        .ZERO_REG  (ZERO_REG)
    ) u_rd (
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .rd_reg    (rd_reg),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag)
    );

    assert_zero_pinned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_REG && (rd_reg[ADDR_W-1:0] == '0)) |-> (rd_valid[0] && (rd_tag[TAG_W-1:0] == '0)));

    assert_read_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && iss_en && !(ZERO_REG && (iss_reg == '0))
         && (rd_reg[ADDR_W-1:0] == iss_reg)) |=> !(rd_valid[0] && (rd_reg[ADDR_W-1:0] == $past(iss_reg))));
endmodule

// File: tb/tb_prod_tag_table.sv
`timescale 1ns/100ps
module tb_prod_tag_table;
    localparam int AW = 5;
    localparam int TW = 4;
    localparam int NP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0, iss_en = 1'b0, wb_en = 1'b0;
    logic [AW-1:0] iss_reg = '0, wb_reg = '0;
    logic [TW-1:0] iss_tag = '0, wb_tag = '0;
    logic [NP*AW-1:0] rd_reg = '0;
    logic [NP-1:0]    g_valid, f_valid;
    logic [NP*TW-1:0] g_tag, f_tag;

    int n_chk = 0, n_fail = 0;
    bit          mg_v [32];
    logic [TW-1:0] mg_t [32];
    bit          mf_v [16];
    logic [TW-1:0] mf_t [16];

    always #2.5 clk = ~clk;

    prod_tag_table #(.ADDR_W(AW), .TAG_W(TW), .RD_PORTS(NP), .HALF_MODE(1'b0), .ZERO_REG(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .iss_en(iss_en), .iss_reg(iss_reg), .iss_tag(iss_tag),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_tag(wb_tag), .rd_reg(rd_reg), .rd_valid(g_valid), .rd_tag(g_tag));

    prod_tag_table #(.ADDR_W(AW), .TAG_W(TW), .RD_PORTS(NP), .HALF_MODE(1'b1), .ZERO_REG(1'b0)) dut_fp (
        .clk(clk), .rst_n(rst_n), .clear(clear), .iss_en(iss_en), .iss_reg(iss_reg), .iss_tag(iss_tag),
        .wb_en(wb_en), .wb_reg(wb_reg), .wb_tag(wb_tag), .rd_reg(rd_reg), .rd_valid(f_valid), .rd_tag(f_tag));

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin mg_v[i] = 1'b1; mg_t[i] = '0; end
        for (int i = 0; i < 16; i++) begin mf_v[i] = 1'b1; mf_t[i] = '0; end
    endtask

    // Expected next state from the requirements: clear > issue > tag-matched writeback
    task automatic model_step();
        int gi, gw, fi, fw;
        gi = int'(iss_reg); gw = int'(wb_reg);
        fi = int'(iss_reg[4:1]); fw = int'(wb_reg[4:1]);
        if (clear) begin
            model_reset();
        end else begin
            if (wb_en && !(iss_en && gi == gw) && mg_t[gw] == wb_tag) mg_v[gw] = 1'b1;
            if (wb_en && !(iss_en && fi == fw) && mf_t[fw] == wb_tag) mf_v[fw] = 1'b1;
            if (iss_en) begin
                mg_v[gi] = 1'b0; mg_t[gi] = iss_tag;
                mf_v[fi] = 1'b0; mf_t[fi] = iss_tag;
            end
        end
    endtask

    task automatic check_reads(string req);
        for (int p = 0; p < NP; p++) begin
            logic [AW-1:0] a;
            bit ev; logic [TW-1:0] et;
            a = rd_reg[p*AW +: AW];
            ev = (a == 0) ? 1'b1 : mg_v[a];
            et = (a == 0) ? '0 : mg_t[a];
            n_chk++;
            if (g_valid[p] !== ev || g_tag[p*TW +: TW] !== et) begin
                n_fail++;
                $display("FAIL %s gen port%0d reg%0d: got v=%0b t=%0d exp v=%0b t=%0d",
                         req, p, a, g_valid[p], g_tag[p*TW +: TW], ev, et);
            end
            n_chk++;
            if (f_valid[p] !== mf_v[a[4:1]] || f_tag[p*TW +: TW] !== mf_t[a[4:1]]) begin
                n_fail++;
                $display("FAIL %s fp port%0d reg%0d: got v=%0b t=%0d exp v=%0b t=%0d",
                         req, p, a, f_valid[p], f_tag[p*TW +: TW], mf_v[a[4:1]], mf_t[a[4:1]]);
            end
        end
    endtask

    // inputs already driven after a negedge: check pre-update reads, clock, update model
    task automatic cycle(string req);
        #1 check_reads(req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        clear = 1'b0; iss_en = 1'b0; wb_en = 1'b0;
    endtask

    task automatic set_rd(int a0, int a1);
        rd_reg = {AW'(a1), AW'(a0)};
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every entry after reset
        for (int r = 0; r < 32; r += 2) begin set_rd(r, r + 1); #1 check_reads("R1"); end
        // R2 + R8: issue reg 5 tag 3, same-cycle read still sees old state
        set_rd(5, 4); iss_en = 1; iss_reg = 5; iss_tag = 3; cycle("R8");
        set_rd(5, 4); cycle("R2");
        // R4: stale tag writeback ignored
        wb_en = 1; wb_reg = 5; wb_tag = 7; cycle("R4");
        cycle("R4");
        // R3: matching writeback releases, tag kept
        wb_en = 1; wb_reg = 5; wb_tag = 3; cycle("R3");
        cycle("R3");
        // R5: younger claim on reg 9 while older retires
        set_rd(9, 8);
        iss_en = 1; iss_reg = 9; iss_tag = 2; cycle("R2");
        iss_en = 1; iss_reg = 9; iss_tag = 4; wb_en = 1; wb_reg = 9; wb_tag = 2; cycle("R5");
        wb_en = 1; wb_reg = 9; wb_tag = 2; cycle("R5");
        cycle("R4");
        // R9: issue to register 0
        set_rd(0, 1); iss_en = 1; iss_reg = 0; iss_tag = 6; cycle("R9");
        cycle("R9");
        // R7: issue and writeback to different entries
        set_rd(10, 9); iss_en = 1; iss_reg = 10; iss_tag = 1; wb_en = 1; wb_reg = 9; wb_tag = 4; cycle("R7");
        cycle("R7");
        // R10: siblings 6 and 7 share an fp entry
        set_rd(6, 7); iss_en = 1; iss_reg = 7; iss_tag = 5; cycle("R10");
        cycle("R10");
        wb_en = 1; wb_reg = 6; wb_tag = 5; cycle("R10");
        cycle("R10");
        // R6: clear beats both ports
        set_rd(10, 11); clear = 1; iss_en = 1; iss_reg = 11; iss_tag = 9; wb_en = 1; wb_reg = 10; wb_tag = 0; cycle("R6");
        for (int r = 0; r < 32; r += 2) begin set_rd(r, r + 1); #1 check_reads("R6"); end
        // R11 / R7 / R3 / R4: constrained random with tag reuse
        for (int i = 0; i < 1500; i++) begin
            iss_en  = ($urandom % 3) != 0;
            iss_reg = AW'($urandom);
            iss_tag = TW'($urandom);
            wb_en   = ($urandom % 2) != 0;
            wb_reg  = ($urandom % 2) ? iss_reg : AW'($urandom);
            wb_tag  = ($urandom % 3 != 0) ? mg_t[wb_reg] : TW'($urandom);
            clear   = ($urandom % 64) == 0;
            set_rd(int'($urandom % 32), int'($urandom % 32));
            cycle("R11");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule